// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block sits in the receive path of a twisted-pair transceiver, after the link monitor and before the bit decoder. It finds out whether the receive pair is wired reversed and, if so, inverts every received data bit. The analog front end reports each link pulse it sees as a strobe with a sign bit. It reports the end delimiter of each frame as a strobe with a sign bit and a validity flag. The link monitor supplies a link-pass level.

The polarity is decided in two stages. While the link is failed, the block counts link pulses of matching sign that arrive back to back. On the cycle the link enters pass, a full run of such pulses seeds the receive polarity. After that, frame end delimiters refine the choice. Two valid delimiters of the same sign in a row fix the polarity and disarm the detector. Losing the link re-arms it. A new polarity is applied to the data path only while no frame is in progress.

Top module: `rx_polarity_corrector`

## Requirements
- R1: After reset, `pol_inv_o` is 0 (normal polarity) and `armed_o` is 1. `lp_accept_o` and `rx_vld_o` are 0.
- R2: The block counts consecutive link pulses of identical sign while `link_pass_i` is 0. A sign change restarts the count at 1. The count saturates at RUN_LEN (5) and is cleared while the link passes. In the first cycle that `link_pass_i` is 1, a count of RUN_LEN sets the target polarity to the sign of the run, where `lp_neg_i`=1 means negative and gives inverted polarity. A shorter run leaves the target polarity unchanged.
- R3: `lp_accept_o` is 1 in the cycle after a pulse strobe in three cases: when the pulse arrives during link fail, when it arrives after disarm, or when its sign matches the target polarity while the link passes and the block is armed. Otherwise `lp_accept_o` is 0.
- R4: While the link passes and the block is armed, two consecutive valid end delimiters of the same sign (`etd_neg_i`=1 means inverted) set the target polarity to that sign. They also drive `armed_o` to 0 in the following cycle.
- R5: Either of two delimiters breaks the pair: a delimiter with `etd_valid_i`=0 clears the consecutive count, and a valid delimiter of the opposite sign restarts the count at 1. In both cases no disarm follows from the earlier delimiter.
- R6: `rx_bit_o` equals `rx_bit_i` XOR `pol_inv_o`, and `rx_vld_o` equals `rx_vld_i`, with one cycle of latency.
- R7: The applied polarity `pol_inv_o` takes the target value only in a cycle where `rx_frame_i` is 0. It never changes during a frame.
- R8: While `link_pass_i` is 0, `armed_o` is 1 and end delimiters are ignored. After disarm, end delimiters and link pulses do not change the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_pass_i | input | 1 | Link monitor state, 1 = pass, 0 = fail |
| lp_stb_i | input | 1 | Link pulse seen (one cycle) |
| lp_neg_i | input | 1 | Sign of the link pulse, 1 = negative |
| etd_stb_i | input | 1 | Frame end delimiter seen (one cycle) |
| etd_neg_i | input | 1 | Sign of the delimiter, 1 = negative |
| etd_valid_i | input | 1 | Delimiter was well formed |
| rx_frame_i | input | 1 | Frame in progress on the receive pair |
| rx_bit_i | input | 1 | Received serial data bit |
| rx_vld_i | input | 1 | Data bit valid |
| rx_bit_o | output | 1 | Polarity-corrected data bit |
| rx_vld_o | output | 1 | Corrected data bit valid |
| pol_inv_o | output | 1 | Applied polarity, 0 = normal, 1 = inverted |
| armed_o | output | 1 | Detection still armed |
| lp_accept_o | output | 1 | Link pulse recognized |

## Verification
Pulse runs are tried in three forms: five negative pulses, five positive pulses, and a run cut short before entering pass. These separate seeding by sign from seeding that is wrongly allowed on a partial run. Delimiter sequences cover three cases: a matching pair, a pair broken by an invalid delimiter, and a pair broken by a sign change. The cases show whether the consecutive count really restarts. A delimiter pair that arrives inside a frame, followed by the frame's end, checks that the data path changes polarity only between frames. Pulses of both signs before and after disarm exercise the recognition filter.

// File: rtl/rx_pol_pkg.sv
package rx_pol_pkg;
    localparam int RUN_LEN = 5;
    localparam int ETD_NEED = 2;

    typedef struct packed {
        logic target;   // chosen polarity, 1 = inverted
        logic applied;  // polarity used by the data path
        logic armed;
        logic accept;
    } ctrl_st_t;

    typedef struct packed {
        logic bit_v;
        logic vld;
    } dp_st_t;
endpackage

// File: rtl/rxp_pulse_run.sv
module rxp_pulse_run #(
    parameter int RUN_LEN = rx_pol_pkg::RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_pass_i,
    input  logic lp_stb_i,
    input  logic lp_neg_i,
    output logic seed_vld_o,
    output logic seed_neg_o
);
    localparam int CW = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          neg;
        logic          link;
    } run_st_t;

    run_st_t run_d, run_q;

    always_comb begin
        run_d      = run_q;
        run_d.link = link_pass_i;
        if (link_pass_i) begin
            run_d.cnt = '0;
        end else if (lp_stb_i) begin
            if (run_q.cnt != '0 && run_q.neg == lp_neg_i) begin
                if (run_q.cnt < CW'(RUN_LEN)) run_d.cnt = run_q.cnt + 1'b1;
            end else begin
                run_d.cnt = CW'(1);
                run_d.neg = lp_neg_i;
            end
        end
        seed_vld_o = link_pass_i && !run_q.link && (run_q.cnt == CW'(RUN_LEN));
        seed_neg_o = run_q.neg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R2: run count never exceeds its saturation value
    assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q.cnt <= CW'(RUN_LEN));
    // R2: the count is empty while the link passes
    assert_run_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        link_pass_i |=> run_q.cnt == '0);
endmodule

// File: rtl/rxp_etd_judge.sv
module rxp_etd_judge #(
    parameter int NEED = rx_pol_pkg::ETD_NEED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic etd_stb_i,
    input  logic etd_neg_i,
    input  logic etd_valid_i,
    output logic lock_o,
    output logic lock_neg_o
);
    localparam int CW = $clog2(NEED + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          neg;
    } etd_st_t;

    etd_st_t etd_d, etd_q;

    always_comb begin
        etd_d      = etd_q;
        lock_o     = 1'b0;
        lock_neg_o = etd_q.neg;
        if (!enable_i) begin
            etd_d.cnt = '0;
        end else if (etd_stb_i) begin
            if (!etd_valid_i) begin
                etd_d.cnt = '0;
            end else if (etd_q.cnt != '0 && etd_q.neg == etd_neg_i) begin
                etd_d.cnt = etd_q.cnt + 1'b1;
            end else begin
                etd_d.cnt = CW'(1);
                etd_d.neg = etd_neg_i;
            end
            if (etd_d.cnt == CW'(NEED)) begin
                lock_o     = 1'b1;
                lock_neg_o = etd_d.neg;
                etd_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) etd_q <= '0;
        else        etd_q <= etd_d;
    end

    // R5: an invalid delimiter empties the consecutive count
    assert_invalid_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && etd_stb_i && !etd_valid_i) |=> etd_q.cnt == '0);
    // R8: nothing is counted while disabled
    assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> etd_q.cnt == '0);
    // R4: a lock needs a strobe of a valid delimiter
    assert_lock_on_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> (etd_stb_i && etd_valid_i && enable_i));
endmodule

// File: rtl/rxp_pol_ctrl.sv
module rxp_pol_ctrl
    import rx_pol_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic link_pass_i,
    input  logic rx_frame_i,
    input  logic lp_stb_i,
    input  logic lp_neg_i,
    input  logic seed_vld_i,
    input  logic seed_neg_i,
    input  logic lock_i,
    input  logic lock_neg_i,
    output logic etd_en_o,
    output logic applied_o,
    output logic armed_o,
    output logic accept_o
);
    ctrl_st_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (!link_pass_i)    ctl_d.armed = 1'b1;
        else if (lock_i)     ctl_d.armed = 1'b0;

        if (lock_i)                      ctl_d.target = lock_neg_i;
        else if (seed_vld_i && ctl_q.armed) ctl_d.target = seed_neg_i;

        if (!rx_frame_i) ctl_d.applied = ctl_q.target;

        ctl_d.accept = lp_stb_i &&
                       (!link_pass_i || !ctl_q.armed || (lp_neg_i == ctl_q.target));

        etd_en_o  = link_pass_i && ctl_q.armed;
        applied_o = ctl_q.applied;
        armed_o   = ctl_q.armed;
        accept_o  = ctl_q.accept;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{target: 1'b0, applied: 1'b0, armed: 1'b1, accept: 1'b0};
        else        ctl_q <= ctl_d;
    end

    // R8: link fail re-arms
    assert_fail_rearms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !link_pass_i |=> ctl_q.armed);
    // R4: disarm only follows a delimiter lock
    assert_disarm_by_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.armed) |-> $past(lock_i));
    // R7: applied polarity frozen during a frame
    assert_no_mid_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_i |=> $stable(ctl_q.applied));
    // R3: recognition only follows a pulse strobe
    assert_accept_needs_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.accept |-> $past(lp_stb_i));
    // R8: once disarmed in pass, target is fixed
    assert_locked_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.armed && link_pass_i) |=> $stable(ctl_q.target));
endmodule

// File: rtl/rxp_datapath.sv
module rxp_datapath
    import rx_pol_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic invert_i,
    input  logic rx_bit_i,
    input  logic rx_vld_i,
    output logic rx_bit_o,
    output logic rx_vld_o
);
    dp_st_t dp_d, dp_q;

    always_comb begin
        dp_d.bit_v = rx_bit_i ^ invert_i;
        dp_d.vld   = rx_vld_i;
        rx_bit_o   = dp_q.bit_v;
        rx_vld_o   = dp_q.vld;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    // R6: valid output always stems from a valid input one cycle earlier
    assert_vld_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dp_q.vld |-> $past(rx_vld_i));
endmodule

// File: rtl/rx_polarity_corrector.sv
module rx_polarity_corrector
    import rx_pol_pkg::*;
#(
    parameter int RUN_LEN  = rx_pol_pkg::RUN_LEN,
    parameter int ETD_NEED = rx_pol_pkg::ETD_NEED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_pass_i,
    input  logic lp_stb_i,
    input  logic lp_neg_i,
    input  logic etd_stb_i,
    input  logic etd_neg_i,
    input  logic etd_valid_i,
    input  logic rx_frame_i,
    input  logic rx_bit_i,
    input  logic rx_vld_i,
    output logic rx_bit_o,
    output logic rx_vld_o,
    output logic pol_inv_o,
    output logic armed_o,
    output logic lp_accept_o
);
    logic seed_vld, seed_neg, lock, lock_neg, etd_en, applied;

    rxp_pulse_run #(.RUN_LEN(RUN_LEN)) i_run (
        .clk(clk), .rst_n(rst_n), .link_pass_i(link_pass_i),
        .lp_stb_i(lp_stb_i), .lp_neg_i(lp_neg_i),
        .seed_vld_o(seed_vld), .seed_neg_o(seed_neg)
    );

    rxp_etd_judge #(.NEED(ETD_NEED)) i_etd (
        .clk(clk), .rst_n(rst_n), .enable_i(etd_en),
        .etd_stb_i(etd_stb_i), .etd_neg_i(etd_neg_i), .etd_valid_i(etd_valid_i),
        .lock_o(lock), .lock_neg_o(lock_neg)
    );

    rxp_pol_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .link_pass_i(link_pass_i), .rx_frame_i(rx_frame_i),
        .lp_stb_i(lp_stb_i), .lp_neg_i(lp_neg_i),
        .seed_vld_i(seed_vld), .seed_neg_i(seed_neg),
        .lock_i(lock), .lock_neg_i(lock_neg),
        .etd_en_o(etd_en), .applied_o(applied), .armed_o(armed_o), .accept_o(lp_accept_o)
    );

    rxp_datapath i_dp (
        .clk(clk), .rst_n(rst_n), .invert_i(applied),
        .rx_bit_i(rx_bit_i), .rx_vld_i(rx_vld_i),
        .rx_bit_o(rx_bit_o), .rx_vld_o(rx_vld_o)
    );

    assign pol_inv_o = applied;

    // R1: out of reset the block is armed
    assert_armed_at_start_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> armed_o);
endmodule

// File: tb/test_rx_polarity_corrector.sv
module test_rx_polarity_corrector;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_pass_i = 1'b0, lp_stb_i = 1'b0, lp_neg_i = 1'b0;
    logic etd_stb_i = 1'b0, etd_neg_i = 1'b0, etd_valid_i = 1'b0;
    logic rx_frame_i = 1'b0, rx_bit_i = 1'b0, rx_vld_i = 1'b0;
    logic rx_bit_o, rx_vld_o, pol_inv_o, armed_o, lp_accept_o;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_polarity_corrector i_rx_polarity_corrector (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic pulse(input logic neg, input logic exp_acc, input string req);
        @(negedge clk); lp_stb_i = 1'b1; lp_neg_i = neg;
        @(negedge clk); lp_stb_i = 1'b0;
        chk(req, lp_accept_o, exp_acc);
    endtask

    task automatic etd(input logic neg, input logic valid);
        @(negedge clk); etd_stb_i = 1'b1; etd_neg_i = neg; etd_valid_i = valid;
        @(negedge clk); etd_stb_i = 1'b0;
    endtask

    task automatic settle(); repeat (3) @(negedge clk); endtask

    task automatic t_reset();
        chk("R1 pol", pol_inv_o, 1'b0);
        chk("R1 armed", armed_o, 1'b1);
        chk("R1 accept", lp_accept_o, 1'b0);
        chk("R1 vld", rx_vld_o, 1'b0);
    endtask

    task automatic t_seed_neg();
        link_pass_i = 1'b0;
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b1, "R3 fail accept");
        @(negedge clk); link_pass_i = 1'b1;
        settle();
        chk("R2 seed inverted", pol_inv_o, 1'b1);
        chk("R2 still armed", armed_o, 1'b1);
    endtask

    task automatic t_filter();
        pulse(1'b1, 1'b1, "R3 matching pulse");
        pulse(1'b0, 1'b0, "R3 opposite pulse");
    endtask

    task automatic t_data();
        logic [3:0] pat = 4'b1011;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); rx_vld_i = 1'b1; rx_bit_i = pat[i];
            @(negedge clk); rx_vld_i = 1'b0;
            chk("R6 vld", rx_vld_o, 1'b1);
            chk("R6 bit", rx_bit_o, pat[i] ^ pol_inv_o);
        end
    endtask

    task automatic t_short_run();
        @(negedge clk); link_pass_i = 1'b0;
        @(negedge clk); chk("R8 rearmed", armed_o, 1'b1);
        for (int i = 0; i < 4; i++) pulse(1'b0, 1'b1, "R3 fail accept");
        @(negedge clk); link_pass_i = 1'b1;
        settle();
        chk("R2 short run keeps pol", pol_inv_o, 1'b1);
    endtask

    task automatic t_seed_pos();
        @(negedge clk); link_pass_i = 1'b0;
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b1, "R3 fail accept");
        for (int i = 0; i < 5; i++) pulse(1'b0, 1'b1, "R3 fail accept");
        @(negedge clk); link_pass_i = 1'b1;
        settle();
        chk("R2 seed normal", pol_inv_o, 1'b0);
    endtask

    task automatic t_etd_break();
        etd(1'b1, 1'b1); etd(1'b1, 1'b0); etd(1'b1, 1'b1);
        settle();
        chk("R5 invalid breaks pair", armed_o, 1'b1);
        chk("R5 pol kept", pol_inv_o, 1'b0);
        etd(1'b0, 1'b1);
        settle();
        chk("R5 sign change breaks pair", armed_o, 1'b1);
        chk("R5 pol kept", pol_inv_o, 1'b0);
        @(negedge clk); link_pass_i = 1'b0;
        etd(1'b1, 1'b1); etd(1'b1, 1'b1);
        @(negedge clk); link_pass_i = 1'b1;
        settle();
        chk("R8 fail ignores delimiters", pol_inv_o, 1'b0);
        chk("R8 armed after fail", armed_o, 1'b1);
    endtask

    task automatic t_lock_mid_frame();
        @(negedge clk); rx_frame_i = 1'b1;
        etd(1'b1, 1'b1); etd(1'b1, 1'b1);
        settle();
        chk("R4 disarmed", armed_o, 1'b0);
        chk("R7 held in frame", pol_inv_o, 1'b0);
        @(negedge clk); rx_frame_i = 1'b0;
        settle();
        chk("R4 locked inverted", pol_inv_o, 1'b1);
        t_data();
    endtask

    task automatic t_after_lock();
        pulse(1'b0, 1'b1, "R3 accept after disarm");
        etd(1'b0, 1'b1); etd(1'b0, 1'b1);
        settle();
        chk("R8 disarmed ignores delimiters", pol_inv_o, 1'b1);
        chk("R8 stays disarmed", armed_o, 1'b0);
        @(negedge clk); link_pass_i = 1'b0;
        @(negedge clk); chk("R8 fail rearms", armed_o, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seed_neg();
        t_filter();
        t_data();
        t_short_run();
        t_seed_pos();
        t_etd_break();
        t_lock_mid_frame();
        t_after_lock();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule